// File: doc/BRIEF.md
# Rotating Frame History Buffer Controller

This block manages the storage behind a pixel-by-pixel background subtraction engine. It keeps a small set of synchronous RAMs, each one frame deep. `NHIST` of them (four by default) hold the most recent complete frames. One more holds the running background estimate. Pixels arrive as a stream with a valid strobe and start-of-frame and end-of-frame markers. For each pixel, the block reads every stored frame and the background at that pixel's address. It presents them to downstream classification logic together with the current pixel.

Frames are never copied between buffers. A rotating pointer names the buffer that holds the oldest frame. That buffer is overwritten in place, at the same address, one cycle after it was read. The history fields are reordered at the output, so downstream logic always sees them oldest first. Downstream logic answers with an updated background value while the block's output is valid. The block writes that value into the background buffer on the following cycle.

After reset, the block fills its history from the first `NHIST` frames. During the last of these frames it also seeds the background buffer with the incoming pixels. Results appear from the first pixel of the next frame onward. The controller has three states:
- `ST_FILL` loads the early frames.
- `ST_SEED` loads the last history frame and the background seed.
- `ST_RUN` produces results.

It moves from `ST_FILL` to `ST_SEED` on the end-of-frame marker that closes frame `NHIST-1`. It moves from `ST_SEED` to `ST_RUN` on the next end-of-frame marker. `ST_RUN` is final until reset. The frame length `FRAME_PIX` must be at least 3, so that the delayed background write never meets a read of the same address.

Top module: `frame_history_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `init_done` and `out_valid` are 0.
- R2: `out_valid` stays 0 for every pixel of the first `NHIST` frames. Classification output begins with the first pixel of frame `NHIST+1`.
- R3: For every pixel of the first output frame, `out_bg` equals the pixel at the same address of frame `NHIST`, the last fill frame.
- R4: `init_done` is 0 until the end-of-frame pixel of frame `NHIST` is accepted. It is 1 from the cycle after that pixel and stays 1 until reset.
- R5: In run mode, each accepted pixel (`in_valid` high at a clock edge) produces exactly one cycle of `out_valid`, one cycle later. `out_pix` in that cycle equals the accepted pixel.
- R6: `out_hist` is in age order. Field k (bits `k*PIX_W` upward) holds the pixel at the same address from the frame received `NHIST-k` frames before the current one. Field 0 is the oldest; field `NHIST-1` is the previous frame.
- R7: The oldest-buffer pointer advances by one, modulo `NHIST`, only on each accepted end-of-frame pixel. The current pixel replaces the oldest entry, so R6 holds across any number of pointer wrap-arounds.
- R8: The `bg_upd` value present while `out_valid` is high is stored for that pixel's address. It appears on `out_bg` for the same address in the next frame.
- R9: Cycles with `in_valid` low produce no output (`out_valid` 0 in the following cycle) and do not advance the pixel address.
- R10: An accepted pixel with `in_sof` high uses address 0. Each further accepted pixel uses the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel is present |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_eof | input | 1 | Marks the last pixel of a frame |
| in_pix | input | PIX_W | Current pixel value |
| bg_upd | input | PIX_W | Updated background from downstream, sampled while `out_valid` is high |
| out_valid | output | 1 | Outputs below are valid for one pixel |
| out_pix | output | PIX_W | Current pixel, delayed one cycle |
| out_hist | output | NHIST*PIX_W | Stored frames at this address, oldest in the low field |
| out_bg | output | PIX_W | Stored background at this address |
| init_done | output | 1 | Fill phase complete, run mode active |

## Verification
A pixel accepted at clock edge E has its result (`out_valid`, `out_pix`, `out_hist`, `out_bg`) valid between E and E+1. The history overwrite commits at E+1, and the background write commits at E+2. The driver applies pixels and pushes one expected item per run-mode pixel into a scoreboard queue. The monitor samples at every falling edge, half a cycle after the edge that updated the outputs. It pops one item for each `out_valid` and treats any `out_valid` with an empty queue as an error. The effect of each delayed write is checked one frame later, when the same address is read again. Idle cycles are checked at the falling edge right after the idle edge, and `init_done` is checked at the falling edge after the relevant end-of-frame pixel.

// File: rtl/fhb_pkg.sv
package fhb_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2
    } fhb_state_e;
endpackage

// File: rtl/fhb_ram.sv
module fhb_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/fhb_age_mux.sv
module fhb_age_mux #(
    parameter int W     = 8,
    parameter int NHIST = 4,
    localparam int PW   = $clog2(NHIST)
) (
    input  logic [PW-1:0]      oldest,
    input  logic [NHIST*W-1:0] phys,
    output logic [NHIST*W-1:0] aged
);
    // Field k takes the buffer k places after the oldest, wrapping.
    always_comb begin
        aged = '0;
        for (int k = 0; k < NHIST; k++) begin
            int s;
            s = int'(oldest) + k;
            if (s >= NHIST) s = s - NHIST;
            aged[k*W +: W] = phys[s*W +: W];
        end
    end
endmodule

// File: rtl/fhb_seq.sv
module fhb_seq
    import fhb_pkg::*;
#(
    parameter int NHIST     = 4,
    parameter int FRAME_PIX = 8,
    localparam int PW       = $clog2(NHIST),
    localparam int AW       = $clog2(FRAME_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic [AW-1:0] pix_addr,
    output logic [PW-1:0] oldest,
    output logic          seed_mode,
    output logic          run_mode,
    output logic          init_done
);
    fhb_state_e    state_q, state_d;
    logic [AW-1:0] cnt_q;
    logic [PW-1:0] oldest_q;
    logic          frame_end;

    assign frame_end = in_valid && in_eof;
    assign pix_addr  = in_sof ? '0 : cnt_q;
    assign oldest    = oldest_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Next state: during fill the oldest pointer equals the frames already stored
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (frame_end && oldest_q == PW'(NHIST-2)) state_d = ST_SEED;
            ST_SEED: if (frame_end) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        seed_mode = 1'b0;
        run_mode  = 1'b0;
        unique case (state_q)
            ST_FILL: ;
            ST_SEED: seed_mode = 1'b1;
            ST_RUN:  run_mode  = 1'b1;
            default: ;
        endcase
        init_done = run_mode;
    end

    // Pixel address and oldest-buffer pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            oldest_q <= '0;
        end else if (in_valid) begin
            if (in_eof || pix_addr == AW'(FRAME_PIX-1)) cnt_q <= '0;
            else                                         cnt_q <= pix_addr + 1'b1;
            if (in_eof)
                oldest_q <= (oldest_q == PW'(NHIST-1)) ? '0 : oldest_q + 1'b1;
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(oldest_q)); // R7

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        run_mode |=> run_mode); // R4
endmodule

// File: rtl/frame_history_ctrl.sv
module frame_history_ctrl #(
    parameter int PIX_W     = 8,
    parameter int NHIST     = 4,
    parameter int FRAME_PIX = 8,
    localparam int PW       = $clog2(NHIST),
    localparam int AW       = $clog2(FRAME_PIX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic                   in_eof,
    input  logic [PIX_W-1:0]       in_pix,
    input  logic [PIX_W-1:0]       bg_upd,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_pix,
    output logic [NHIST*PIX_W-1:0] out_hist,
    output logic [PIX_W-1:0]       out_bg,
    output logic                   init_done
);
    logic [AW-1:0]          pix_addr;
    logic [PW-1:0]          oldest;
    logic                   seed_mode, run_mode;

    // Slot 1: pixel read issued last edge, history overwrite now
    logic                   v1_q, seed1_q, run1_q;
    logic [AW-1:0]          addr1_q;
    logic [PIX_W-1:0]       pix1_q;
    logic [PW-1:0]          old1_q;
    // Slot 2: background write
    logic                   v2_q;
    logic [AW-1:0]          addr2_q;
    logic [PIX_W-1:0]       bgw_q;

    logic [NHIST*PIX_W-1:0] phys_rd;
    logic [NHIST-1:0]       hist_we;

    fhb_seq #(.NHIST(NHIST), .FRAME_PIX(FRAME_PIX)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .pix_addr  (pix_addr),
        .oldest    (oldest),
        .seed_mode (seed_mode),
        .run_mode  (run_mode),
        .init_done (init_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            seed1_q <= 1'b0;
            run1_q  <= 1'b0;
            addr1_q <= '0;
            pix1_q  <= '0;
            old1_q  <= '0;
            v2_q    <= 1'b0;
            addr2_q <= '0;
            bgw_q   <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                seed1_q <= seed_mode;
                run1_q  <= run_mode;
                addr1_q <= pix_addr;
                pix1_q  <= in_pix;
                old1_q  <= oldest;
            end
            v2_q <= v1_q && (seed1_q || run1_q);
            if (v1_q) begin
                addr2_q <= addr1_q;
                bgw_q   <= run1_q ? bg_upd : pix1_q;
            end
        end
    end

    for (genvar i = 0; i < NHIST; i++) begin : g_hist
        assign hist_we[i] = v1_q && (old1_q == PW'(i));
        fhb_ram #(.W(PIX_W), .DEPTH(FRAME_PIX)) ram_i (
            .clk   (clk),
            .we    (hist_we[i]),
            .waddr (addr1_q),
            .wdata (pix1_q),
            .raddr (pix_addr),
            .rdata (phys_rd[i*PIX_W +: PIX_W])
        );
    end

    fhb_ram #(.W(PIX_W), .DEPTH(FRAME_PIX)) bg_ram_i (
        .clk   (clk),
        .we    (v2_q),
        .waddr (addr2_q),
        .wdata (bgw_q),
        .raddr (pix_addr),
        .rdata (out_bg)
    );

    fhb_age_mux #(.W(PIX_W), .NHIST(NHIST)) age_i (
        .oldest (old1_q),
        .phys   (phys_rd),
        .aged   (out_hist)
    );

    assign out_valid = v1_q && run1_q;
    assign out_pix   = pix1_q;

    AST_QUIET_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> init_done); // R2

    AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && init_done) |=> (out_valid && out_pix == $past(in_pix))); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_SINGLE_HIST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hist_we) && ($countones(hist_we) == 32'(v1_q))); // R7
endmodule

// File: tb/frame_history_ctrl_tb_top.sv
module frame_history_ctrl_tb_top;
    localparam int PIX_W     = 8;
    localparam int NHIST     = 4;
    localparam int FRAME_PIX = 8;
    localparam int HW        = NHIST * PIX_W;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic [HW-1:0]    hist;
        logic [PIX_W-1:0] bg;
        logic             first;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic [PIX_W-1:0] bg_upd;
    logic             out_valid, init_done;
    logic [PIX_W-1:0] out_pix, out_bg;
    logic [HW-1:0]    out_hist;

    int n_checks = 0;
    int n_fail   = 0;
    int frames_sent = 0;
    exp_t exp_q[$];
    logic [PIX_W-1:0] hist_m [NHIST][FRAME_PIX];
    logic [PIX_W-1:0] bg_m [FRAME_PIX];

    always #5 clk = ~clk;

    // Downstream background rule used by the bench: current pixel plus 3
    assign bg_upd = out_pix + 8'd3;

    frame_history_ctrl #(.PIX_W(PIX_W), .NHIST(NHIST), .FRAME_PIX(FRAME_PIX)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_pix(in_pix), .bg_upd(bg_upd), .out_valid(out_valid), .out_pix(out_pix),
        .out_hist(out_hist), .out_bg(out_bg), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [PIX_W-1:0] pixfn(input int f, input int a);
        return PIX_W'((f * 37 + a * 29 + 7) ^ (f * a * 3));
    endfunction

    // Driver: called at a falling edge; leaves at a falling edge
    task automatic send_frame(input int gap_every, input int cval);
        logic [PIX_W-1:0] cur [FRAME_PIX];
        for (int a = 0; a < FRAME_PIX; a++) begin
            logic [PIX_W-1:0] p;
            exp_t e;
            if (gap_every > 0 && a > 0 && (a % gap_every) == 0) begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                @(negedge clk);
                if (frames_sent >= NHIST)
                    check(out_valid == 1'b0, "R9", "out_valid after idle cycle", 64'(out_valid), 64'd0);
            end
            p = (cval >= 0) ? PIX_W'(cval) : pixfn(frames_sent, a);
            in_valid = 1'b1; in_sof = (a == 0); in_eof = (a == FRAME_PIX - 1); in_pix = p;
            if (frames_sent >= NHIST) begin
                e.pix = p;
                for (int k = 0; k < NHIST; k++) e.hist[k*PIX_W +: PIX_W] = hist_m[k][a];
                e.bg = bg_m[a];
                e.first = (frames_sent == NHIST);
                exp_q.push_back(e);
                bg_m[a] = p + 8'd3;
            end else if (frames_sent == NHIST - 1) begin
                bg_m[a] = p;
            end
            cur[a] = p;
            @(negedge clk);
        end
        for (int k = 0; k < NHIST - 1; k++)
            for (int a = 0; a < FRAME_PIX; a++) hist_m[k][a] = hist_m[k+1][a];
        for (int a = 0; a < FRAME_PIX; a++) hist_m[NHIST-1][a] = cur[a];
        frames_sent++;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "out_valid with no pixel due", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_pix == e.pix, "R5", "out_pix", 64'(out_pix), 64'(e.pix));
                check(out_hist == e.hist, "R6 R7", "out_hist age order", 64'(out_hist), 64'(e.hist));
                if (e.first)
                    check(out_bg == e.bg, "R3", "seeded out_bg", 64'(out_bg), 64'(e.bg));
                else
                    check(out_bg == e.bg, "R8", "updated out_bg", 64'(out_bg), 64'(e.bg));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(init_done == 1'b0, "R1", "init_done in reset", 64'(init_done), 64'd0);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(init_done == 1'b0, "R1", "init_done after reset", 64'(init_done), 64'd0);

        // Fill frames, with idle gaps inside to exercise R10 addressing
        send_frame(0, -1);
        send_frame(3, -1);
        send_frame(2, -1);
        check(init_done == 1'b0, "R4", "init_done before last fill frame", 64'(init_done), 64'd0);
        send_frame(0, -1);
        check(init_done == 1'b1, "R4", "init_done after last fill frame", 64'(init_done), 64'd1);

        // Run frames: back-to-back, gapped, constant patterns, several pointer wraps
        send_frame(0, -1);
        send_frame(2, -1);
        send_frame(0, 8'hFF);
        send_frame(3, 0);
        send_frame(0, -1);
        send_frame(1, -1);
        send_frame(0, 8'hA5);
        send_frame(4, -1);
        send_frame(0, -1);
        send_frame(5, -1);
        idle(4);
        check(exp_q.size() == 0, "R5", "results outstanding", 64'(exp_q.size()), 64'd0);
        check(init_done == 1'b1, "R4", "init_done held in run", 64'(init_done), 64'd1);
        check(out_valid == 1'b0, "R9", "out_valid while idle", 64'(out_valid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule